// File: doc/BRIEF.md
# Shared-MAC Sixteen-Tap FIR Filter

This block computes a sixteen-tap finite impulse response filter with a single signed multiply-accumulate unit that is reused across all taps. A small three-state controller steps a tap address through the coefficient store and the sample delay line. The same controller also drives the coefficient write enable and the accumulator clear. One filter output is produced every sixteen clock cycles.

After reset the controller spends sixteen cycles loading coefficients from `coef_i`, one per cycle in ascending address order. It then alternates between a clear cycle at address 0 and a fifteen-cycle sweep over addresses 1 to 15. A new input sample is taken from `sample_i` once per period. The completed sum is presented with a one-cycle strobe. Coefficients stay fixed until the next reset.

Top module: `tmux_fir`

## Requirements
- R1: In the 16 cycles that follow reset release (cycle 0 is the cycle that starts at release), the value on `coef_i` in cycle k is stored as the coefficient for tap k, for k = 0..15.
- R2: `sample_i` is captured at the clock edge that ends cycle 15 and at every 16th edge after that. The sample captured most recently is multiplied by coefficient 0, and the sample captured j periods earlier is multiplied by coefficient j. Reset clears every delay-line stage to zero.
- R3: `valid_o` is high for exactly one cycle, first in cycle 32 and then every 16 cycles. It is low in every other cycle.
- R4: Coefficients are loaded only once per reset. Values on `coef_i` after cycle 15 have no effect on any result.
- R5: In a strobe cycle, `result_o` equals the sum over k of coef[k] times the tap-k sample of the period that just ended, with no contribution from earlier periods. The accumulator clear happens in the same cycle as the strobe.
- R6: Operands are two's-complement signed. The sum wraps modulo 2^ACC_W (18 bits by default) on overflow.
- R7: The controller goes from the clear cycle (address 0, write enable low) into the sweep. In the sweep the address rises by one per cycle, and at address 15 the controller returns to the clear cycle.
- R8: An asynchronous reset asserted mid-period abandons the current sum and restarts coefficient loading.
- R9: While reset is held, `valid_o` is 0 and `result_o` is 0. `valid_o` stays 0 during loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| coef_i | input | COEF_W (9) | Signed coefficient, read during loading |
| sample_i | input | DATA_W (9) | Signed input sample, captured once per period |
| result_o | output | ACC_W (18) | Signed filter output |
| valid_o | output | 1 | One-cycle strobe marking a completed result |

## Verification
The output strobe and the accumulator clear always fall in the same cycle. In that cycle the register still holds the finished sum while the adder input is switched to zero. The bench provokes this with back-to-back periods of large random samples and full-scale values that wrap. It checks every strobed result against a bench model that starts each sum from zero. A result carrying any part of the previous sum, or one sampled a cycle late, therefore mismatches. Sample capture and the last product of a sweep also share a clock edge. An impulse stream exposes this: it must return the coefficients in tap order.

// File: rtl/tmux_fir_pkg.sv
`timescale 1ns/1ps
package tmux_fir_pkg;
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_CLEAR = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/tmux_fir_ctrl.sv
`timescale 1ns/1ps
module tmux_fir_ctrl
  import tmux_fir_pkg::*;
#(
  parameter int TAPS   = 16,
  parameter int ADDR_W = $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output ctrl_state_e       state_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wen_o,
  output logic              clr_o,
  output logic              mac_en_o,
  output logic              shift_o,
  output logic              valid_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TAPS - 1);

  ctrl_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_LOAD;
      addr_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_LOAD: begin
          if (addr_q == LAST) begin
            state_q <= ST_CLEAR;
            addr_q  <= '0;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_CLEAR: begin
          state_q  <= ST_SWEEP;
          addr_q   <= addr_q + 1'b1;
          primed_q <= 1'b1;
        end
        default: begin
          if (addr_q == LAST) begin
            state_q <= ST_CLEAR;
            addr_q  <= '0;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign state_o  = state_q;
  assign addr_o   = addr_q;
  assign wen_o    = (state_q == ST_LOAD);
  assign clr_o    = (state_q == ST_CLEAR);
  assign mac_en_o = (state_q != ST_LOAD);
  // new sample enters on the edge that closes a load or a sweep
  assign shift_o  = (state_q != ST_CLEAR) && (addr_q == LAST);
  assign valid_o  = (state_q == ST_CLEAR) && primed_q;
endmodule

// File: rtl/tmux_fir_coef_mem.sv
`timescale 1ns/1ps
module tmux_fir_coef_mem #(
  parameter int TAPS   = 16,
  parameter int COEF_W = 9,
  parameter int ADDR_W = $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [COEF_W-1:0] wdata_i,
  output logic [COEF_W-1:0] rdata_o
);
  logic [COEF_W-1:0] mem_q [TAPS];

  for (genvar i = 0; i < TAPS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[i] <= '0;
      else if (we_i && (addr_i == ADDR_W'(i)))    mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/tmux_fir_delay.sv
`timescale 1ns/1ps
module tmux_fir_delay #(
  parameter int TAPS   = 16,
  parameter int DATA_W = 9,
  parameter int ADDR_W = $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] tap_o
);
  logic [DATA_W-1:0] line_q [TAPS];

  for (genvar i = 0; i < TAPS; i++) begin : g_stage
    logic [DATA_W-1:0] din;
    if (i == 0) begin : g_head
      assign din = sample_i;
    end else begin : g_body
      assign din = line_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      line_q[i] <= '0;
      else if (shift_i) line_q[i] <= din;
    end
  end

  assign tap_o = line_q[addr_i];
endmodule

// File: rtl/tmux_fir_mac.sv
`timescale 1ns/1ps
module tmux_fir_mac #(
  parameter int DATA_W = 9,
  parameter int COEF_W = 9,
  parameter int ACC_W  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic [DATA_W-1:0] tap_i,
  output logic [ACC_W-1:0]  acc_o
);
  logic signed [ACC_W-1:0] coef_x, tap_x, prod, base, acc_q;

  assign coef_x = ACC_W'($signed(coef_i));
  assign tap_x  = ACC_W'($signed(tap_i));
  assign prod   = coef_x * tap_x;
  assign base   = clr_i ? '0 : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= base + prod;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/tmux_fir.sv
`timescale 1ns/1ps
module tmux_fir
  import tmux_fir_pkg::*;
#(
  parameter int TAPS   = 16,
  parameter int DATA_W = 9,
  parameter int COEF_W = 9,
  parameter int ACC_W  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COEF_W-1:0] coef_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [ACC_W-1:0]  result_o,
  output logic              valid_o
);
  localparam int ADDR_W = $clog2(TAPS);

  ctrl_state_e       state_w;
  logic [ADDR_W-1:0] addr_w;
  logic              wen_w, clr_w, mac_en_w, shift_w;
  logic [COEF_W-1:0] coef_rd_w;
  logic [DATA_W-1:0] tap_rd_w;

  tmux_fir_ctrl #(.TAPS(TAPS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni,
    .state_o (state_w),
    .addr_o  (addr_w),
    .wen_o   (wen_w),
    .clr_o   (clr_w),
    .mac_en_o(mac_en_w),
    .shift_o (shift_w),
    .valid_o (valid_o)
  );

  tmux_fir_coef_mem #(.TAPS(TAPS), .COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_coef (
    .clk_i, .rst_ni,
    .we_i   (wen_w),
    .addr_i (addr_w),
    .wdata_i(coef_i),
    .rdata_o(coef_rd_w)
  );

  tmux_fir_delay #(.TAPS(TAPS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_line (
    .clk_i, .rst_ni,
    .shift_i (shift_w),
    .sample_i(sample_i),
    .addr_i  (addr_w),
    .tap_o   (tap_rd_w)
  );

  tmux_fir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk_i, .rst_ni,
    .en_i  (mac_en_w),
    .clr_i (clr_w),
    .coef_i(coef_rd_w),
    .tap_i (tap_rd_w),
    .acc_o (result_o)
  );
endmodule

// File: rtl/tmux_fir_chk.sv
`timescale 1ns/1ps
module tmux_fir_chk
  import tmux_fir_pkg::*;
#(
  parameter int TAPS   = 16,
  parameter int ADDR_W = $clog2(TAPS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input ctrl_state_e       state_w,
  input logic [ADDR_W-1:0] addr_w,
  input logic              wen_w,
  input logic              clr_w,
  input logic              valid_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TAPS - 1);

  AST_CLEAR_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w |-> (addr_w == '0) && !wen_w); // R7
  AST_SWEEP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_SWEEP && addr_w != LAST) |=>
      (state_w == ST_SWEEP) && (addr_w == ADDR_W'($past(addr_w) + 1'b1))); // R7
  AST_SWEEP_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_SWEEP && addr_w == LAST) |=> clr_w); // R7
  AST_CLEAR_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w |=> (state_w == ST_SWEEP)); // R7
  AST_LOAD_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_w |=> !wen_w); // R4
  AST_VALID_WITH_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> clr_w); // R5
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R3
  AST_NO_VALID_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_w |-> !valid_o); // R9
endmodule

bind tmux_fir tmux_fir_chk #(.TAPS(TAPS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .state_w(state_w),
  .addr_w (addr_w),
  .wen_w  (wen_w),
  .clr_w  (clr_w),
  .valid_o(valid_o)
);

// File: tb/sim_tmux_fir.sv
`timescale 1ns/1ps
module sim_tmux_fir;
  localparam int TAPS   = 16;
  localparam int DATA_W = 9;
  localparam int COEF_W = 9;
  localparam int ACC_W  = 18;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [COEF_W-1:0] coef_i = '0;
  logic [DATA_W-1:0] sample_i = '0;
  logic [ACC_W-1:0]  result_o;
  logic              valid_o;

  int checks = 0;
  int errors = 0;
  int coef_m [TAPS];
  int hist [TAPS];
  int mode = 0;
  int imp_cnt = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  tmux_fir #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u0 (
    .clk_i, .rst_ni, .coef_i, .sample_i, .result_o, .valid_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int rnd9();
    return int'($urandom_range(510)) - 255;
  endfunction

  function automatic int gen_sample();
    case (mode)
      1: begin imp_cnt++; return (imp_cnt == 1) ? 1 : 0; end
      2: return 255;
      default: return rnd9();
    endcase
  endfunction

  function automatic logic [ACC_W-1:0] model_y();
    longint s = 0;
    for (int k = 0; k < TAPS; k++) s += longint'(coef_m[k]) * longint'(hist[k]);
    return s[ACC_W-1:0];
  endfunction

  task automatic push(input int s);
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = s;
  endtask

  // R9: outputs idle while reset is held
  task automatic hold_reset();
    rst_ni = 1'b0;
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    imp_cnt = 0;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R9 valid in reset", valid_o, 0);
    chk(result_o == '0, "R9 result in reset", result_o, 0);
    rst_ni = 1'b1;
  endtask

  // R1: coefficient k is taken in cycle k after release
  task automatic load(input int cmode);
    int s;
    for (int k = 0; k < TAPS; k++) begin
      case (cmode)
        0: coef_m[k] = k + 1;
        1: coef_m[k] = 255;
        default: coef_m[k] = rnd9();
      endcase
    end
    s = gen_sample();
    for (int k = 0; k < TAPS; k++) begin
      coef_i = COEF_W'(coef_m[k]);
      if (k == 0) sample_i = DATA_W'(s);
      chk(valid_o == 1'b0, "R9 valid during load", valid_o, 0);
      @(negedge clk_i);
    end
    push(s);
  endtask

  // R2 R3 R4 R5: run periods, junk on coef_i, check every cycle
  task automatic run(input int n, input string tag);
    logic [ACC_W-1:0] cap_exp, chk_exp;
    int s;
    cap_exp = model_y();
    chk_exp = '0;
    for (int p = 0; p < n; p++) begin
      if (p == 0) chk(valid_o == 1'b0, "R3 no strobe in first clear", valid_o, 0);
      else begin
        chk(valid_o == 1'b1, "R3 strobe in clear cycle", valid_o, 1);
        chk(result_o == chk_exp, tag, $signed(result_o), $signed(chk_exp));
      end
      chk_exp = cap_exp;
      s = gen_sample();
      sample_i = DATA_W'(s);
      for (int c = 0; c < TAPS; c++) begin
        coef_i = COEF_W'(rnd9()); // R4 ignored after load
        if (c != 0) chk(valid_o == 1'b0, "R3 strobe off between results", valid_o, 0);
        @(negedge clk_i);
      end
      push(s);
      cap_exp = model_y();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    @(negedge clk_i);

    // directed: impulse returns coefficients in tap order (R1 R2)
    mode = 1;
    hold_reset();
    load(0);
    run(20, "R2 impulse response");

    // random samples, random junk on coef_i (R4 R5)
    mode = 0;
    hold_reset();
    load(2);
    run(40, "R5 random sum");

    // full scale wrap (R6)
    mode = 2;
    hold_reset();
    load(1);
    run(19, "R6 wrapped sum");

    // reset in the middle of a period, then reload (R8)
    mode = 0;
    hold_reset();
    load(2);
    run(5, "R5 pre-reset sum");
    repeat (7) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(valid_o == 1'b0, "R8 strobe dropped on reset", valid_o, 0);
    chk(result_o == '0, "R8 sum abandoned", result_o, 0);
    hold_reset();
    load(2);
    run(20, "R8 sum after reload");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule